// File: doc/BRIEF.md
# In-Place Vector Add Engine

The engine adds two vectors of 32-bit words, one held in memory A and one in memory B, and writes each sum back into A at the same index. The vector length is fixed. Work begins as soon as reset is released, with no start command. The engine then streams through every index without stalling.

The engine reaches memory A through two ports and memory B through one. Port 0 of A and the port of B read element i. Port 1 of A writes back the sum of an element read two cycles earlier, so reads and write-back overlap and one element completes every cycle. The memories sit outside the block. Each one returns read data one cycle after it sees an address.

A `ready` output goes high once the last write has been issued. It stays high until the next reset, and no further writes are made during that time.

Top module: `vadd_engine`

## Requirements
- R1: In cycle i after reset is released (cycle 0 is the first cycle with reset low), the engine presents address i on both read ports (A port 0 and B), for i = 0 to 255.
- R2: Read addresses rise by exactly one per cycle, with no gap and no repeat, from 0 up to 255.
- R3: The value written for element i is A[i] + B[i] modulo 2^32, and the carry-out is dropped. After the run, memory A holds these sums at every index.
- R4: The sum for element i is driven on A port 1 in cycle i+2, with address i and mode 1 (1 = write, 0 = read). A write never targets the address being read in the same cycle.
- R5: A port 0 and the B port always carry mode 0 (read) and write data 0. During reset, A port 1 carries mode 0.
- R6: `ready` is 0 during reset and through cycle 257. It is 1 from cycle 258 and stays 1 until the next reset.
- R7: While `ready` is 1, A port 1 carries mode 0, so no write is made.
- R8: Reset applied in the middle of a run abandons that run. After release, a new run starts again from element 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ready | output | 1 | High once every element has been written |
| a0_addr | output | 8 | A port 0 address (reads) |
| a0_wdata | output | 32 | A port 0 write data, always 0 |
| a0_rdata | input | 32 | A port 0 read data, one cycle after address |
| a0_mode | output | 1 | A port 0 mode, always 0 (read) |
| b_addr | output | 8 | B port address |
| b_wdata | output | 32 | B port write data, always 0 |
| b_rdata | input | 32 | B port read data, one cycle after address |
| b_mode | output | 1 | B port mode, always 0 (read) |
| a1_addr | output | 8 | A port 1 address (write-back) |
| a1_wdata | output | 32 | A port 1 write data (sum) |
| a1_mode | output | 1 | A port 1 mode, 1 = write |

## Verification
The bench targets the following corner cases.

- **Wrap-around sums.** Pairs whose sum overflows, such as 0xFFFFFFFF + 1 and 0x80000000 + 0x80000000, expose an adder that keeps the carry or sign-extends the result.
- **Pipeline boundaries.** The first and last elements reveal an off-by-one in the delay to write-back. Such a fault shows up as a shifted write address, a stale sum, or `ready` rising one cycle early or late.
- **Quiet after completion.** The bench watches A port 1 for many cycles after `ready` rises. An engine that keeps streaming would corrupt A at this point.
- **Reset in mid-run.** A reset issued during a run must restart the count at element 0. A design that resumed from the old index would skip elements.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

    localparam int ELEMS  = 256;
    localparam int WORD_W = 32;
    localparam int ADDR_W = $clog2(ELEMS);

    typedef logic [ADDR_W-1:0] idx_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } mode_e;

    // read request tag: travels with an element down the pipeline
    typedef struct packed {
        logic vld;
        idx_t idx;
    } tag_t;

    // write-back record: element index plus its sum
    typedef struct packed {
        logic  vld;
        idx_t  idx;
        word_t sum;
    } wr_t;

    function automatic word_t wrap_add(input word_t x, input word_t y);
        return x + y;
    endfunction

endpackage

// File: rtl/vadd_issue.sv
module vadd_issue
    import vadd_pkg::*;
#(
    parameter int N = ELEMS
) (
    input  logic clk,
    input  logic rst,
    output tag_t rd_tag
);

    localparam idx_t LAST = idx_t'(N - 1);

    idx_t idx;
    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (idx == LAST) begin
                run <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign rd_tag = '{vld: run, idx: idx};

    AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run) && run) |-> (idx == $past(idx) + 1'b1)); // R2

endmodule

// File: rtl/vadd_sum.sv
module vadd_sum
    import vadd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  in_tag,
    input  word_t a_rd,
    input  word_t b_rd,
    output wr_t   wr
);

    tag_t data_tag;   // element whose read data is on a_rd/b_rd this cycle

    always_ff @(posedge clk) begin
        if (rst) begin
            data_tag <= '0;
            wr       <= '0;
        end else begin
            data_tag <= in_tag;
            wr.vld   <= data_tag.vld;
            wr.idx   <= data_tag.idx;
            wr.sum   <= wrap_add(a_rd, b_rd);
        end
    end

    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |->
        ((wr.vld == $past(in_tag.vld, 2)) &&
         (!wr.vld || wr.idx == $past(in_tag.idx, 2)))); // R4

endmodule

// File: rtl/vadd_wb.sv
module vadd_wb
    import vadd_pkg::*;
#(
    parameter int N = ELEMS
) (
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wr,
    output idx_t  wb_addr,
    output word_t wb_data,
    output mode_e wb_mode,
    output logic  ready
);

    localparam idx_t LAST = idx_t'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
        end else if (wr.vld && wr.idx == LAST) begin
            ready <= 1'b1;
        end
    end

    assign wb_addr = wr.idx;
    assign wb_data = wr.sum;
    assign wb_mode = wr.vld ? MODE_WR : MODE_RD;

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R6

    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (wb_mode == MODE_RD)); // R7

endmodule

// File: rtl/vadd_engine.sv
module vadd_engine
    import vadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic              ready,
    output logic [ADDR_W-1:0] a0_addr,
    output logic [WORD_W-1:0] a0_wdata,
    input  logic [WORD_W-1:0] a0_rdata,
    output logic              a0_mode,
    output logic [ADDR_W-1:0] b_addr,
    output logic [WORD_W-1:0] b_wdata,
    input  logic [WORD_W-1:0] b_rdata,
    output logic              b_mode,
    output logic [ADDR_W-1:0] a1_addr,
    output logic [WORD_W-1:0] a1_wdata,
    output logic              a1_mode
);

    tag_t  rd_tag;
    wr_t   wr;
    mode_e wb_mode;

    vadd_issue #(.N(ELEMS)) u_issue (
        .clk    (clk),
        .rst    (rst),
        .rd_tag (rd_tag)
    );

    vadd_sum u_sum (
        .clk    (clk),
        .rst    (rst),
        .in_tag (rd_tag),
        .a_rd   (a0_rdata),
        .b_rd   (b_rdata),
        .wr     (wr)
    );

    vadd_wb #(.N(ELEMS)) u_wb (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wb_addr (a1_addr),
        .wb_data (a1_wdata),
        .wb_mode (wb_mode),
        .ready   (ready)
    );

    assign a0_addr  = rd_tag.idx;
    assign b_addr   = rd_tag.idx;
    assign a0_mode  = MODE_RD;
    assign b_mode   = MODE_RD;
    assign a0_wdata = '0;
    assign b_wdata  = '0;
    assign a1_mode  = (wb_mode == MODE_WR);

    AST_NO_RAW_CLASH: assert property (@(posedge clk) disable iff (rst)
        (a1_mode && rd_tag.vld) |-> (a1_addr != rd_tag.idx)); // R4

endmodule

// File: tb/vadd_engine_test.sv
`timescale 1ns/1ps
module vadd_engine_test;

    localparam int N = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready;
    logic [7:0]  a0_addr, b_addr, a1_addr;
    logic [31:0] a0_wdata, b_wdata, a1_wdata;
    logic [31:0] a0_rdata, b_rdata;
    logic        a0_mode, b_mode, a1_mode;

    logic [31:0] mem_a [N];
    logic [31:0] mem_b [N];
    logic [31:0] expect_a [N];

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vadd_engine uut (
        .clk(clk), .rst(rst), .ready(ready),
        .a0_addr(a0_addr), .a0_wdata(a0_wdata), .a0_rdata(a0_rdata), .a0_mode(a0_mode),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mode(b_mode),
        .a1_addr(a1_addr), .a1_wdata(a1_wdata), .a1_mode(a1_mode)
    );

    // memory models: one-cycle read latency, write on port 1 of A
    always @(posedge clk) begin
        a0_rdata <= mem_a[a0_addr];
        b_rdata  <= mem_b[b_addr];
        if (a1_mode) mem_a[a1_addr] <= a1_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] add32(input logic [31:0] x, input logic [31:0] y);
        logic [32:0] full;
        full = {1'b0, x} + {1'b0, y};
        return full[31:0];
    endfunction

    // Runs the engine from reset release. abort_at < 0 runs to completion.
    task automatic run_engine(input int abort_at);
        for (int i = 0; i < N; i++) expect_a[i] = add32(mem_a[i], mem_b[i]);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < N + 2 + 20; c++) begin
            if (c == abort_at) begin
                chk(a0_addr == 8'(c), "R1 addr before abort", {24'd0, a0_addr}, c);
                rst = 1'b1;
                repeat (3) @(negedge clk);
                return;
            end
            if (c < N) begin
                if (a0_addr != 8'(c) || b_addr != 8'(c))
                    chk(1'b0, "R1/R2 read address", {24'd0, a0_addr}, c);
            end
            if (a0_mode || b_mode || a0_wdata != 0 || b_wdata != 0)
                chk(1'b0, "R5 read ports stay read", {30'd0, a0_mode, b_mode}, 0);
            if (c >= 2 && c < N + 2) begin
                if (!a1_mode || a1_addr != 8'(c - 2) || a1_wdata != expect_a[c - 2])
                    chk(1'b0, "R3/R4 write-back", a1_wdata, expect_a[c - 2]);
                if (a1_addr == a0_addr && c < N)
                    chk(1'b0, "R4 write hits read address", {24'd0, a1_addr}, c);
            end
            if (c < 2 && a1_mode) chk(1'b0, "R4 early write", 1, 0);
            if (c == 0) chk(a0_addr == 0, "R8 run begins at element 0", {24'd0, a0_addr}, 0);
            if (c == 2) chk(a1_mode && a1_addr == 0, "R4 first write in cycle 2", {24'd0, a1_addr}, 0);
            if (c == N + 1) chk(a1_addr == 8'(N - 1) && !ready, "R4/R6 last write, ready low", {23'd0, ready, a1_addr}, N - 1);
            if (c == N + 1) chk(!ready, "R6 ready low in cycle 257", ready, 0);
            if (c == N + 2) chk(ready, "R6 ready high in cycle 258", ready, 1);
            if (c > N + 2) begin
                if (!ready) chk(1'b0, "R6 ready sticky", ready, 1);
                if (a1_mode) chk(1'b0, "R7 write after ready", a1_mode, 0);
            end
            @(negedge clk);
        end
        chk(ready && !a1_mode, "R7 quiet at end", {30'd0, ready, a1_mode}, 2);
        begin
            int bad = 0;
            for (int i = 0; i < N; i++) if (mem_a[i] != expect_a[i]) bad++;
            chk(bad == 0, "R3 final memory A", bad, 0);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            mem_a[i] = $urandom;
            mem_b[i] = $urandom;
        end
        repeat (3) @(negedge clk);
        chk(!ready, "R6 ready low in reset", ready, 0);
        chk(!a1_mode, "R5 no write in reset", a1_mode, 0);
        chk(!a0_mode && !b_mode, "R5 read modes in reset", {30'd0, a0_mode, b_mode}, 0);

        // random data
        run_engine(-1);

        // overflow corners mixed with random
        for (int i = 0; i < N; i++) begin
            case (i % 4)
                0: begin mem_a[i] = 32'hFFFF_FFFF; mem_b[i] = 32'h1; end
                1: begin mem_a[i] = 32'h8000_0000; mem_b[i] = 32'h8000_0000; end
                2: begin mem_a[i] = 32'hFFFF_FFFF; mem_b[i] = 32'hFFFF_FFFF; end
                default: begin mem_a[i] = $urandom; mem_b[i] = $urandom; end
            endcase
        end
        run_engine(-1);
        chk(mem_a[0] == 0, "R3 FFFFFFFF+1 wraps", mem_a[0], 0);
        chk(mem_a[1] == 0, "R3 80000000*2 wraps", mem_a[1], 0);
        chk(mem_a[2] == 32'hFFFF_FFFE, "R3 max+max", mem_a[2], 32'hFFFF_FFFE);

        // zeros in A: result equals B
        for (int i = 0; i < N; i++) begin
            mem_a[i] = 0;
            mem_b[i] = i * 32'h0101_0101;
        end
        run_engine(-1);
        chk(mem_a[N - 1] == 32'hFFFF_FFFF, "R3 last element", mem_a[N - 1], 32'hFFFF_FFFF);

        // reset in mid-run, then restart from 0
        for (int i = 0; i < N; i++) begin
            mem_a[i] = $urandom;
            mem_b[i] = $urandom;
        end
        run_engine(100);
        chk(!ready, "R8 ready cleared by reset", ready, 0);
        run_engine(-1);

        summary();
    end

endmodule